// File: doc/BRIEF.md
# Memory-to-Stream Burst Reader

This block copies one contiguous region of memory onto a streaming output. A controller supplies a source address, a largest burst length, a beat size and a total byte count, then pulses the start input. The engine splits the region into incrementing read bursts. It issues one burst at a time on an AXI4 read master and pushes every returned beat through an internal FIFO onto an AXI4-Stream master. When it returns to idle it raises a one-cycle done pulse.

Each burst is sized in two registered preparation cycles. The first cycle clips the nominal burst to the end of the current 4 KB page. The second cycle clips the result to the bytes still owed and converts it to a beat count. A stop pulse requests an early end. The engine honours it while it is preparing a burst. If a burst is already in flight, it finishes that burst and then stops.

Top module: `mem_to_stream_dma`

## Requirements
- R1: After reset, the read address valid, read ready, stream valid and done outputs are all low.
- R2: A transfer begins only on a low-to-high transition of the start input. Holding start high after a transfer has finished launches nothing further.
- R3: A burst that no page end or byte count clips carries (max_len+1) << beat_size bytes, with ARLEN equal to max_len and ARSIZE equal to the commanded beat size.
- R4: No burst crosses a 4096-byte address boundary. When the page offset plus the nominal bytes reaches 4096, the burst holds 4096 minus the offset bytes. ARLEN is the ceiling of those bytes over the beat bytes, minus one.
- R5: A burst that would pass the end of the region is cut to the remaining byte count, with ARLEN rounded up in the same way.
- R6: After each accepted address the source address advances by that burst's byte count and the remaining count drops by the same amount. Bursts therefore tile the region in order with no gap or overlap.
- R7: Every burst uses INCR type (ARBURST = 2'b01), and ARID, ARLOCK, ARCACHE, ARPROT, ARQOS and ARUSER are all zero.
- R8: Read ready is high only in the data phase of an accepted burst. A read beat offered while the engine is idle or waiting on its address is not taken.
- R9: Read beats leave on the stream in arrival order under backpressure. TLAST is high on the final beat of the whole region and on no other beat.
- R10: A stop pulse during burst preparation returns the engine to idle with no further address issued. A stop pulse after an address has been accepted lets that burst complete, with no TLAST, and then returns to idle. A later start clears the stop.
- R11: Done is a single-cycle pulse, raised once each time the engine returns to idle.
- R12: A transfer with a total byte count of zero returns to idle with a done pulse and issues no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start request, acted on at its rising edge |
| cmd_stop | input | 1 | Stop request, acted on at its rising edge |
| cmd_src_addr | input | ADDR_W | First byte address of the region |
| cmd_max_len | input | 8 | Largest ARLEN the engine may use |
| cmd_beat_size | input | 3 | ARSIZE code for every burst |
| cmd_total_bytes | input | XFER_W | Region length in bytes |
| cmd_done | output | 1 | One-cycle pulse on return to idle |
| m_arid | output | ID_W | Read ID, zero |
| m_araddr | output | ADDR_W | Burst start address |
| m_arlen | output | 8 | Beats in burst minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type, INCR |
| m_arlock | output | 1 | Lock, zero |
| m_arcache | output | 4 | Cache attributes, zero |
| m_arprot | output | 3 | Protection, zero |
| m_arqos | output | 4 | QoS, zero |
| m_aruser | output | USER_W | User sideband, zero |
| m_arvalid | output | 1 | Address valid |
| m_arready | input | 1 | Address ready |
| m_rid | input | ID_W | Read ID, ignored |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response, ignored |
| m_rlast | input | 1 | Last beat of burst |
| m_ruser | input | USER_W | Read user sideband, ignored |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| st_tdata | output | DATA_W | Stream data |
| st_tlast | output | 1 | Final beat of the region |
| st_tvalid | output | 1 | Stream valid |
| st_tready | input | 1 | Stream ready |

## Verification
A wrong sizing register shows up on the very next address handshake as an ARLEN or ARADDR that differs from the value computed by hand for the page and byte-count clips. A wrong remaining count shows up a burst later as an extra or missing burst and a misplaced TLAST. A wrong phase decision shows up in the same cycle as read ready going high outside the data phase, or as a stall in which no burst ever starts and the done pulse never comes. The abort latch is checked by counting addresses and the done pulse after a stop arrives at each point in the flow.

// File: rtl/m2s_pkg.sv
`timescale 1ns/1ps
package m2s_pkg;

    localparam int BYTES_W    = 16;
    localparam int BYTES_W1   = BYTES_W + 1;
    localparam int PAGE_BITS  = 12;
    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIZE_A,
        ST_SIZE_B,
        ST_ADDR,
        ST_DATA
    } dma_state_e;

    typedef struct packed {
        logic [7:0] max_len;
        logic [2:0] size;
    } burst_shape_t;

    // Nominal bytes of a burst: (len + 1) beats of (1 << size) bytes.
    function automatic logic [BYTES_W-1:0] shape_bytes(input burst_shape_t s);
        logic [BYTES_W-1:0] beats;
        beats = BYTES_W'(s.max_len) + BYTES_W'(1);
        return beats << s.size;
    endfunction

    // Beat count rounded up, minus one; zero bytes give zero.
    function automatic logic [7:0] bytes_to_len(input logic [BYTES_W-1:0] nbytes,
                                                input logic [2:0]         size);
        logic [BYTES_W1-1:0] padded;
        logic [BYTES_W1-1:0] beats;
        padded = {1'b0, nbytes} + (BYTES_W1'(1) << size) - BYTES_W1'(1);
        beats  = padded >> size;
        if (beats == '0)
            return 8'd0;
        return 8'(beats - BYTES_W1'(1));
    endfunction

endpackage

// File: rtl/m2s_burst_sizer.sv
`timescale 1ns/1ps
module m2s_burst_sizer
    import m2s_pkg::*;
#(
    parameter int XFER_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stage_a_en,
    input  logic                 stage_b_en,
    input  logic [PAGE_BITS-1:0] page_offset,
    input  burst_shape_t         shape,
    input  logic [XFER_W-1:0]    remaining,
    output logic [7:0]           burst_len,
    output logic [BYTES_W-1:0]   burst_bytes
);

    logic [BYTES_W-1:0] full_bytes;
    logic [BYTES_W-1:0] page_room;
    logic [BYTES_W-1:0] clipped_d;
    logic [BYTES_W-1:0] page_clip_q;
    logic [BYTES_W-1:0] taken;
    logic               crosses;

    // Stage A: clip the nominal burst at the end of the current page.
    assign full_bytes = shape_bytes(shape);
    assign page_room  = BYTES_W'(PAGE_BYTES) - BYTES_W'(page_offset);
    assign crosses    = (BYTES_W1'(full_bytes) + BYTES_W1'(page_offset)) >= BYTES_W1'(PAGE_BYTES);
    assign clipped_d  = crosses ? page_room : full_bytes;

    always_ff @(posedge clk) begin
        if (rst)
            page_clip_q <= '0;
        else if (stage_a_en)
            page_clip_q <= clipped_d;
    end

    // Stage B: clip again to the bytes still owed, then turn into ARLEN.
    assign taken = (XFER_W'(page_clip_q) <= remaining) ? page_clip_q : remaining[BYTES_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_len   <= '0;
            burst_bytes <= '0;
        end else if (stage_b_en) begin
            burst_len   <= bytes_to_len(taken, shape.size);
            burst_bytes <= taken;
        end
    end

endmodule

// File: rtl/m2s_fifo.sv
`timescale 1ns/1ps
module m2s_fifo #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;
    logic             do_wr;
    logic             do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (fill == CNT_W'(DEPTH));
    assign empty   = (fill == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_wr)
                wr_ptr <= bump(wr_ptr);
            if (do_rd)
                rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr)
            store[wr_ptr] <= wr_data;
    end

endmodule

// File: rtl/mem_to_stream_dma.sv
`timescale 1ns/1ps
module mem_to_stream_dma
    import m2s_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int ID_W       = 4,
    parameter int USER_W     = 1,
    parameter int XFER_W     = 32,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [ADDR_W-1:0] cmd_src_addr,
    input  logic [7:0]        cmd_max_len,
    input  logic [2:0]        cmd_beat_size,
    input  logic [XFER_W-1:0] cmd_total_bytes,
    output logic              cmd_done,
    output logic [ID_W-1:0]   m_arid,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    output logic              m_arlock,
    output logic [3:0]        m_arcache,
    output logic [2:0]        m_arprot,
    output logic [3:0]        m_arqos,
    output logic [USER_W-1:0] m_aruser,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [ID_W-1:0]   m_rid,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast,
    input  logic [USER_W-1:0] m_ruser,
    input  logic              m_rvalid,
    output logic              m_rready,
    output logic [DATA_W-1:0] st_tdata,
    output logic              st_tlast,
    output logic              st_tvalid,
    input  logic              st_tready
);

    localparam int ENTRY_W = DATA_W + 1;

    logic               start_q;
    logic               stop_q;
    logic               start_edge;
    logic               stop_edge;
    logic               abort_q;
    logic               launch;
    dma_state_e         state;
    dma_state_e         state_d;
    logic [ADDR_W-1:0]  src_q;
    burst_shape_t       shape_q;
    logic [XFER_W-1:0]  remaining_q;
    logic [7:0]         burst_len;
    logic [BYTES_W-1:0] burst_bytes;
    logic               ar_fire;
    logic               r_fire;
    logic               final_burst;
    logic               done_q;
    logic               fifo_full;
    logic               fifo_empty;
    logic [ENTRY_W-1:0] fifo_in;
    logic [ENTRY_W-1:0] fifo_out;
    logic               unused_sideband;

    assign unused_sideband = ^{m_rid, m_rresp, m_ruser};

    // Edge detection on the control pulses and the abort latch.
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            start_q <= cmd_start;
            stop_q  <= cmd_stop;
            if (stop_edge)
                abort_q <= 1'b1;
            else if (start_edge)
                abort_q <= 1'b0;
        end
    end

    assign start_edge  = cmd_start && !start_q;
    assign stop_edge   = cmd_stop && !stop_q;
    assign launch      = (state == ST_IDLE) && start_edge && !stop_edge;
    assign ar_fire     = m_arvalid && m_arready;
    assign r_fire      = m_rvalid && m_rready;
    assign final_burst = (remaining_q == '0);

    // Phase sequencing.
    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE:   if (launch) state_d = ST_SIZE_A;
            ST_SIZE_A: state_d = (abort_q || remaining_q == '0) ? ST_IDLE : ST_SIZE_B;
            ST_SIZE_B: state_d = abort_q ? ST_IDLE : ST_ADDR;
            ST_ADDR:   if (ar_fire) state_d = ST_DATA;
            ST_DATA:   if (r_fire && m_rlast)
                           state_d = (abort_q || final_burst) ? ST_IDLE : ST_SIZE_A;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            state  <= state_d;
            done_q <= (state != ST_IDLE) && (state_d == ST_IDLE);
        end
    end

    // Address and byte bookkeeping.
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q       <= '0;
            shape_q     <= '0;
            remaining_q <= '0;
        end else if (launch) begin
            src_q       <= cmd_src_addr;
            shape_q     <= '{max_len: cmd_max_len, size: cmd_beat_size};
            remaining_q <= cmd_total_bytes;
        end else if (ar_fire) begin
            src_q       <= src_q + ADDR_W'(burst_bytes);
            remaining_q <= remaining_q - XFER_W'(burst_bytes);
        end
    end

    m2s_burst_sizer #(
        .XFER_W (XFER_W)
    ) u_sizer (
        .clk         (clk),
        .rst         (rst),
        .stage_a_en  (state == ST_SIZE_A),
        .stage_b_en  (state == ST_SIZE_B),
        .page_offset (src_q[PAGE_BITS-1:0]),
        .shape       (shape_q),
        .remaining   (remaining_q),
        .burst_len   (burst_len),
        .burst_bytes (burst_bytes)
    );

    // Read data buffer between the read channel and the stream.
    assign m_rready = (state == ST_DATA) && !fifo_full;
    assign fifo_in  = {m_rdata, m_rlast && final_burst};

    m2s_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (m_rvalid && m_rready),
        .wr_data (fifo_in),
        .full    (fifo_full),
        .rd_en   (st_tvalid && st_tready),
        .rd_data (fifo_out),
        .empty   (fifo_empty)
    );

    assign st_tvalid = !fifo_empty;
    assign st_tdata  = fifo_out[ENTRY_W-1:1];
    assign st_tlast  = fifo_out[0];

    // Read address channel.
    assign m_arvalid = (state == ST_ADDR);
    assign m_araddr  = src_q;
    assign m_arlen   = burst_len;
    assign m_arsize  = shape_q.size;
    assign m_arburst = 2'b01;
    assign m_arlock  = 1'b0;
    assign m_arcache = '0;
    assign m_arprot  = '0;
    assign m_arqos   = '0;
    assign m_arid    = '0;
    assign m_aruser  = '0;

    assign cmd_done = done_q;

endmodule

// File: rtl/m2s_dma_checker.sv
`timescale 1ns/1ps
module m2s_dma_checker
    import m2s_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              arvalid,
    input logic              arready,
    input logic [ADDR_W-1:0] araddr,
    input logic [7:0]        arlen,
    input logic [2:0]        arsize,
    input logic              rready,
    input logic              tvalid,
    input logic              tready,
    input logic [DATA_W-1:0] tdata,
    input logic              tlast,
    input logic              done,
    input dma_state_e        state,
    input logic              abort_q,
    input logic [7:0]        cap_len
);

    logic aligned;
    assign aligned = (araddr & ((ADDR_W'(1) << arsize) - ADDR_W'(1))) == '0;

    // R3: a burst never exceeds the commanded length
    a_r3_len_cap: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> arlen <= cap_len);

    // R4: an aligned burst ends at or before its page end
    a_r4_page_end: assert property (@(posedge clk) disable iff (rst)
        (arvalid && aligned) |->
            (17'(araddr[PAGE_BITS-1:0]) + ((17'(arlen) + 17'd1) << arsize)) <= 17'(PAGE_BYTES));

    // R6: a pending request holds its address and length
    a_r6_ar_hold: assert property (@(posedge clk) disable iff (rst)
        (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlen)));

    // R8: read ready never overlaps a pending address
    a_r8_rready_phase: assert property (@(posedge clk) disable iff (rst)
        rready |-> !arvalid);

    // R8: the data phase is entered only through an address handshake
    a_r8_data_after_ar: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_DATA) |-> $past(arvalid && arready));

    // R9: a stalled stream beat holds its contents
    a_r9_stream_hold: assert property (@(posedge clk) disable iff (rst)
        (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

    // R10: an abort seen in preparation leads straight to idle
    a_r10_abort_prep: assert property (@(posedge clk) disable iff (rst)
        (abort_q && (state == ST_SIZE_A || state == ST_SIZE_B)) |=> state == ST_IDLE);

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind mem_to_stream_dma m2s_dma_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .arvalid (m_arvalid),
    .arready (m_arready),
    .araddr  (m_araddr),
    .arlen   (m_arlen),
    .arsize  (m_arsize),
    .rready  (m_rready),
    .tvalid  (st_tvalid),
    .tready  (st_tready),
    .tdata   (st_tdata),
    .tlast   (st_tlast),
    .done    (cmd_done),
    .state   (state),
    .abort_q (abort_q),
    .cap_len (shape_q.max_len)
);

// File: tb/sim_mem_to_stream_dma.sv
`timescale 1ns/1ps
module sim_mem_to_stream_dma;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int ID_W   = 4;
    localparam int USER_W = 1;
    localparam int XFER_W = 32;
    localparam int DEPTH  = 8;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  len;
        logic [2:0]  size;
        logic [31:0] total;
    } vec_t;

    // address, max length, beat size, total bytes
    localparam vec_t VECS [0:6] = '{
        '{32'h0000_1000, 8'd3,   3'd2, 32'd64},   // R3 plain bursts
        '{32'h0000_1FF0, 8'd7,   3'd2, 32'd40},   // R4 page clip then R5 tail
        '{32'h0000_0300, 8'd15,  3'd1, 32'd10},   // R5 single short burst
        '{32'h0000_0FFC, 8'd0,   3'd2, 32'd12},   // R6 single-beat bursts across a page
        '{32'h0000_2000, 8'd255, 3'd0, 32'd300},  // R3 longest burst, R5 tail
        '{32'h0000_5F80, 8'd63,  3'd2, 32'd600},  // R4 page clip, R6 chain
        '{32'h0000_0040, 8'd1,   3'd2, 32'd7}     // R5 rounding up
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_start = 1'b0;
    logic              cmd_stop = 1'b0;
    logic [ADDR_W-1:0] cmd_src_addr = '0;
    logic [7:0]        cmd_max_len = '0;
    logic [2:0]        cmd_beat_size = '0;
    logic [XFER_W-1:0] cmd_total_bytes = '0;
    logic              cmd_done;
    logic [ID_W-1:0]   m_arid;
    logic [ADDR_W-1:0] m_araddr;
    logic [7:0]        m_arlen;
    logic [2:0]        m_arsize;
    logic [1:0]        m_arburst;
    logic              m_arlock;
    logic [3:0]        m_arcache;
    logic [2:0]        m_arprot;
    logic [3:0]        m_arqos;
    logic [USER_W-1:0] m_aruser;
    logic              m_arvalid;
    logic              m_arready = 1'b0;
    logic [DATA_W-1:0] m_rdata = '0;
    logic              m_rlast = 1'b0;
    logic              m_rvalid = 1'b0;
    logic              m_rready;
    logic [DATA_W-1:0] st_tdata;
    logic              st_tlast;
    logic              st_tvalid;
    logic              st_tready = 1'b0;

    always #2.5 clk = ~clk;

    mem_to_stream_dma #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ID_W       (ID_W),
        .USER_W     (USER_W),
        .XFER_W     (XFER_W),
        .FIFO_DEPTH (DEPTH)
    ) u0 (
        .clk             (clk),
        .rst             (rst),
        .cmd_start       (cmd_start),
        .cmd_stop        (cmd_stop),
        .cmd_src_addr    (cmd_src_addr),
        .cmd_max_len     (cmd_max_len),
        .cmd_beat_size   (cmd_beat_size),
        .cmd_total_bytes (cmd_total_bytes),
        .cmd_done        (cmd_done),
        .m_arid          (m_arid),
        .m_araddr        (m_araddr),
        .m_arlen         (m_arlen),
        .m_arsize        (m_arsize),
        .m_arburst       (m_arburst),
        .m_arlock        (m_arlock),
        .m_arcache       (m_arcache),
        .m_arprot        (m_arprot),
        .m_arqos         (m_arqos),
        .m_aruser        (m_aruser),
        .m_arvalid       (m_arvalid),
        .m_arready       (m_arready),
        .m_rid           ('0),
        .m_rdata         (m_rdata),
        .m_rresp         (2'b00),
        .m_rlast         (m_rlast),
        .m_ruser         ('0),
        .m_rvalid        (m_rvalid),
        .m_rready        (m_rready),
        .st_tdata        (st_tdata),
        .st_tlast        (st_tlast),
        .st_tvalid       (st_tvalid),
        .st_tready       (st_tready)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected burst list, computed from the requirements.
    longint exp_addr [0:255];
    int     exp_len  [0:255];
    int     exp_n;
    int     exp_beats;

    task automatic plan_bursts(input vec_t v);
        longint a;
        longint rem;
        longint b;
        longint lo;
        longint bb;
        longint beats;
        a = v.addr;
        rem = v.total;
        exp_n = 0;
        exp_beats = 0;
        while (rem > 0) begin
            b  = (longint'(v.len) + 1) << v.size;
            lo = a % 4096;
            if (lo + b >= 4096) b = 4096 - lo;
            if (b > rem) b = rem;
            bb = longint'(1) << v.size;
            beats = (b + bb - 1) / bb;
            exp_addr[exp_n] = a;
            exp_len[exp_n]  = int'(beats - 1);
            exp_n++;
            exp_beats += int'(beats);
            a += b;
            rem -= b;
        end
    endtask

    // Memory and stream-sink model, all driving at the falling edge.
    bit         model_en = 1'b0;
    bit         force_rvalid = 1'b0;
    bit         stop_at_ar = 1'b0;
    bit         r_taken = 1'b0;
    int         cyc = 0;
    int         ar_idx = 0;
    int         r_left = 0;
    int         rseq = 0;
    int         rx = 0;
    int         tlast_n = 0;
    int         done_n = 0;
    logic [2:0] cur_size = '0;

    always @(negedge clk) begin
        cyc++;
        if (model_en) begin
            if (r_taken) m_rvalid = 1'b0;
            r_taken = 1'b0;
            if (r_left > 0) begin
                if (!m_rvalid) m_rvalid = (cyc % 5 != 2);
                m_rdata = DATA_W'(rseq);
                m_rlast = (r_left == 1);
                if (m_rvalid && m_rready) begin
                    r_taken = 1'b1;
                    rseq++;
                    r_left--;
                end
            end else begin
                m_rvalid = 1'b0;
                m_rlast  = 1'b0;
            end

            m_arready = (cyc % 3 != 1);
            if (m_arvalid && m_arready) begin
                if (ar_idx < exp_n) begin
                    chk(m_araddr == exp_addr[ar_idx], "R6", "burst address", m_araddr, exp_addr[ar_idx]);
                    chk(int'(m_arlen) == exp_len[ar_idx], "R4 R5", "burst length", m_arlen, exp_len[ar_idx]);
                end else begin
                    chk(1'b0, "R6", "unexpected burst", ar_idx + 1, exp_n);
                end
                chk(m_arsize == cur_size, "R3", "beat size", m_arsize, cur_size);
                chk(m_arburst == 2'b01 && !m_arlock && m_arcache == '0 && m_arprot == '0 &&
                    m_arqos == '0 && m_arid == '0 && m_aruser == '0,
                    "R7", "fixed attributes", m_arburst, 1);
                ar_idx++;
                r_left += int'(m_arlen) + 1;
                if (stop_at_ar) cmd_stop = 1'b1;
            end

            st_tready = (cyc % 4 != 3);
            if (st_tvalid && st_tready) begin
                chk(st_tdata == DATA_W'(rx), "R9", "stream order", st_tdata, rx);
                chk(st_tlast == (rx == exp_beats - 1), "R9", "tlast placement", st_tlast, rx == exp_beats - 1);
                if (st_tlast) tlast_n++;
                rx++;
            end
        end else begin
            m_rvalid  = force_rvalid;
            m_rlast   = force_rvalid;
            m_rdata   = 32'hA5A5_0001;
            m_arready = 1'b0;
            st_tready = 1'b1;
        end
        if (cmd_done) done_n++;
    end

    task automatic reset_model(input logic [2:0] sz);
        ar_idx = 0;
        rx = 0;
        rseq = 0;
        tlast_n = 0;
        done_n = 0;
        cur_size = sz;
    endtask

    task automatic settle();
        int k;
        k = 0;
        while (done_n == 0 && k < 6000) begin
            @(negedge clk);
            k++;
        end
        repeat (60) @(negedge clk);
    endtask

    task automatic launch(input vec_t v, input bit hold);
        @(negedge clk);
        cmd_src_addr    = v.addr;
        cmd_max_len     = v.len;
        cmd_beat_size   = v.size;
        cmd_total_bytes = v.total;
        cmd_start       = 1'b1;
        if (!hold) begin
            @(negedge clk);
            cmd_start = 1'b0;
        end
    endtask

    task automatic run_vec(input vec_t v, input bit hold, input string tag);
        plan_bursts(v);
        reset_model(v.size);
        launch(v, hold);
        settle();
        chk(ar_idx == exp_n, tag, "burst count", ar_idx, exp_n);
        chk(rx == exp_beats, "R9", "beat count", rx, exp_beats);
        chk(tlast_n == ((exp_beats > 0) ? 1 : 0), "R9", "tlast count", tlast_n, (exp_beats > 0) ? 1 : 0);
        chk(done_n == 1, "R11", "done pulses", done_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog expired: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk(!m_arvalid, "R1", "arvalid after reset", m_arvalid, 0);
        chk(!m_rready, "R1", "rready after reset", m_rready, 0);
        chk(!st_tvalid, "R1", "tvalid after reset", st_tvalid, 0);
        chk(!cmd_done, "R1", "done after reset", cmd_done, 0);

        // R8 read beats offered while idle are refused
        force_rvalid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!m_rready, "R8", "rready while idle", m_rready, 0);
        end
        force_rvalid = 1'b0;
        @(negedge clk);
        chk(!st_tvalid, "R8", "nothing buffered from idle beats", st_tvalid, 0);

        // R3 R4 R5 R6 R7 R9 R11: the vector table
        model_en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            run_vec(VECS[i], 1'b0, "R6");
        end

        // R12 zero-byte transfer
        v = '{32'h0000_0100, 8'd3, 3'd2, 32'd0};
        run_vec(v, 1'b0, "R12");

        // R10 stop during burst preparation
        v = '{32'h0000_1000, 8'd3, 3'd2, 32'd64};
        exp_n = 0;
        exp_beats = 0;
        reset_model(v.size);
        launch(v, 1'b0);
        cmd_stop = 1'b1;
        settle();
        chk(ar_idx == 0, "R10", "bursts after early stop", ar_idx, 0);
        chk(rx == 0, "R10", "beats after early stop", rx, 0);
        chk(done_n == 1, "R10", "done after early stop", done_n, 1);
        cmd_stop = 1'b0;

        // R10 stop once the first address is accepted
        plan_bursts(v);
        reset_model(v.size);
        stop_at_ar = 1'b1;
        launch(v, 1'b0);
        settle();
        stop_at_ar = 1'b0;
        chk(ar_idx == 1, "R10", "bursts after late stop", ar_idx, 1);
        chk(rx == exp_len[0] + 1, "R10", "beats after late stop", rx, exp_len[0] + 1);
        chk(tlast_n == 0, "R10", "tlast after late stop", tlast_n, 0);
        chk(done_n == 1, "R10", "done after late stop", done_n, 1);
        cmd_stop = 1'b0;

        // R10 a new start clears the stop; R2 start held high does not relaunch
        v = VECS[2];
        run_vec(v, 1'b1, "R10");
        repeat (80) @(negedge clk);
        chk(ar_idx == exp_n, "R2", "no relaunch while start held", ar_idx, exp_n);
        chk(done_n == 1, "R2", "single done while start held", done_n, 1);
        cmd_start = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule